// File: doc/BRIEF.md
# Multiply-accumulate unit

This block is a sequential multiply-accumulate datapath. On every clock edge where it is enabled, it multiplies two unsigned operands at full precision. It then adds the product to a running sum held in a wide register. The register output feeds back as one addend of the next addition, so a stream of operand pairs presented on consecutive cycles yields their dot product. A synchronous clear starts a new sum from the current product, without a dead cycle between sums.

The product is twice the operand width. The running sum is one bit wider than the product. The feedback addition first splits into per-bit sum and carry vectors, then resolves them with a rippled carry. A carry that leaves the top bit of the sum sets a sticky overflow flag, and the sum itself wraps.

The control decode picks one of three named register operations on each cycle:
- **HOLD**: enable low.
- **LOAD**: enable and clear both high.
- **ACCUM**: enable high, clear low.

Every operation can follow every other on the next cycle. There are no further control states.

Top module: `mac_unit`

## Requirements
- R1: An active-low asynchronous reset sets the sum to zero and clears the overflow flag, without waiting for a clock edge.
- R2: With enable high and clear low, the sum after the next rising edge is (previous sum + op_a*op_b) modulo 2^(2*OP_W+1).
- R3: The overflow flag goes high on an ACCUM cycle whose addition carries out of the top sum bit. Once high, it stays high through later ACCUM and HOLD cycles.
- R4: With enable low, the sum and the overflow flag keep their values, whatever clear and the operands do.
- R5: With enable and clear both high, the sum after the next rising edge is op_a*op_b alone and the overflow flag is cleared.
- R6: The product is kept at full width (2*OP_W bits) without truncation, including when both operands are all ones.
- R7: Operands and control are taken on every cycle, and each result is visible one rising edge after its operands, with no bubble between back-to-back operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low selects HOLD |
| clr | input | 1 | With en high, selects LOAD instead of ACCUM |
| op_a | input | OP_W | Unsigned multiplicand |
| op_b | input | OP_W | Unsigned multiplier |
| acc_sum | output | 2*OP_W+1 | Running sum |
| acc_ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest condition to reach from the ports is a carry out of the top sum bit. Even two all-ones products stay below the wrap point, so at least three near-maximal products must be accumulated without an intervening clear. The stimulus does this deliberately with a LOAD of all-ones operands followed by two ACCUMs. The random phase biases operands towards all-ones and zero so that wraps recur, and it mixes in HOLD and LOAD cycles. These cycles show the flag surviving holds and being dropped only by a clear or a reset.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_ACCUM = 2'b10
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
    parameter int OP_W = 64
) (
    input  logic [OP_W-1:0]   mul_a,
    input  logic [OP_W-1:0]   mul_b,
    output logic [2*OP_W-1:0] mul_p
);

    localparam int P_W = 2 * OP_W;

    logic [P_W-1:0] ext_a;
    logic [P_W-1:0] ext_b;

    // Both factors widened first so the product is never cut to OP_W bits.
    assign ext_a = {{OP_W{1'b0}}, mul_a};
    assign ext_b = {{OP_W{1'b0}}, mul_b};
    assign mul_p = ext_a * ext_b;

endmodule

// File: rtl/mac_csa.sv
`timescale 1ns/1ps
module mac_csa #(
    parameter int W = 129
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    output logic [W-1:0] add_s,
    output logic         add_co
);

    logic [W-1:0] half_s;
    logic [W-1:0] half_c;
    logic [W-1:0] shift_c;
    logic         rip;

    // Per-bit half-add stage: parity and generate vectors.
    assign half_s  = add_x ^ add_y;
    assign half_c  = add_x & add_y;
    assign shift_c = {half_c[W-2:0], 1'b0};

    // Ripple resolution of the two vectors.
    always_comb begin
        rip = 1'b0;
        for (int i = 0; i < W; i++) begin
            add_s[i] = half_s[i] ^ shift_c[i] ^ rip;
            rip      = (half_s[i] & shift_c[i]) | (rip & (half_s[i] ^ shift_c[i]));
        end
        // Either the dropped top generate bit or the ripple end leaves the word.
        add_co = rip | half_c[W-1];
    end

endmodule

// File: rtl/mac_acc_reg.sv
`timescale 1ns/1ps
module mac_acc_reg
    import mac_pkg::*;
#(
    parameter int W = 129
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mac_op_e       op_sel,
    input  logic [W-1:0]  load_val,
    input  logic [W-1:0]  accum_val,
    input  logic          accum_co,
    output logic [W-1:0]  q,
    output logic          ovf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= 1'b0;
        end else begin
            unique case (op_sel)
                OP_LOAD: begin
                    q   <= load_val;
                    ovf <= 1'b0;
                end
                OP_ACCUM: begin
                    q   <= accum_val;
                    ovf <= ovf | accum_co;
                end
                default: begin
                    q   <= q;
                    ovf <= ovf;
                end
            endcase
        end
    end

endmodule

// File: rtl/mac_unit.sv
`timescale 1ns/1ps
module mac_unit
    import mac_pkg::*;
#(
    parameter int OP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [2*OP_W:0]   acc_sum,
    output logic              acc_ovf
);

    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = PROD_W + 1;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  prod_ext;
    logic [ACC_W-1:0]  csa_sum;
    logic              csa_co;
    mac_op_e           op_sel;

    always_comb begin
        unique case ({en, clr})
            2'b10:   op_sel = OP_ACCUM;
            2'b11:   op_sel = OP_LOAD;
            default: op_sel = OP_HOLD;
        endcase
    end

    mac_mult #(.OP_W(OP_W)) u_mult (
        .mul_a (op_a),
        .mul_b (op_b),
        .mul_p (prod)
    );

    assign prod_ext = {1'b0, prod};

    mac_csa #(.W(ACC_W)) u_csa (
        .add_x  (prod_ext),
        .add_y  (acc_sum),
        .add_s  (csa_sum),
        .add_co (csa_co)
    );

    mac_acc_reg #(.W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .load_val  (prod_ext),
        .accum_val (csa_sum),
        .accum_co  (csa_co),
        .q         (acc_sum),
        .ovf       (acc_ovf)
    );

endmodule

// File: rtl/mac_unit_chk.sv
`timescale 1ns/1ps
module mac_unit_chk #(
    parameter int OP_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            clr,
    input logic [2*OP_W:0] acc_sum,
    input logic            acc_ovf
);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(acc_sum) && $stable(acc_ovf)));

    // A loaded product never reaches the top sum bit and the flag drops (R5).
    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr) |=> (!acc_ovf && !acc_sum[2*OP_W]));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ovf && !(en && clr)) |=> acc_ovf);

    assert_ovf_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_ovf) |-> $past(en && !clr));

    // An accumulate that makes the sum smaller must be a wrap (R2).
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> ((acc_sum >= $past(acc_sum)) || acc_ovf));

endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .clr     (clr),
    .acc_sum (acc_sum),
    .acc_ovf (acc_ovf)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;

    localparam int OP_W  = 64;
    localparam int ACC_W = 2 * OP_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              clr = 1'b0;
    logic [OP_W-1:0]   op_a = '0;
    logic [OP_W-1:0]   op_b = '0;
    logic [ACC_W-1:0]  acc_sum;
    logic              acc_ovf;

    logic [ACC_W-1:0]  ref_sum = '0;
    logic              ref_ovf = 1'b0;
    int                n_checks = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    mac_unit #(.OP_W(OP_W)) u_mac_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .clr     (clr),
        .op_a    (op_a),
        .op_b    (op_b),
        .acc_sum (acc_sum),
        .acc_ovf (acc_ovf)
    );

    task automatic check(input string tag);
        n_checks++;
        if (acc_sum !== ref_sum || acc_ovf !== ref_ovf) begin
            n_fail++;
            $display("FAIL %s actual sum=%h ovf=%0b expected sum=%h ovf=%0b",
                     tag, acc_sum, acc_ovf, ref_sum, ref_ovf);
        end
    endtask

    // Apply one cycle of stimulus, predict, and compare at the next falling edge.
    task automatic step(input logic e, input logic c,
                        input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                        input string tag);
        logic [2*OP_W-1:0] p;
        logic [ACC_W:0]    wide;
        en   = e;
        clr  = c;
        op_a = a;
        op_b = b;
        p = {{OP_W{1'b0}}, a} * {{OP_W{1'b0}}, b};
        if (e) begin
            if (c) begin
                ref_sum = {1'b0, p};
                ref_ovf = 1'b0;
            end else begin
                wide    = {1'b0, ref_sum} + {2'b00, p};
                ref_ovf = ref_ovf | wide[ACC_W];
                ref_sum = wide[ACC_W-1:0];
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [OP_W-1:0] rand_op();
        logic [127:0] w;
        w = {$urandom, $urandom, $urandom, $urandom};
        case ($urandom % 6)
            0:       return '0;
            1, 2:    return '1;
            default: return w[OP_W-1:0];
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;

        // R2 / R7: back-to-back small accumulations
        step(1'b1, 1'b0, 64'd3,  64'd5,  "R2");
        step(1'b1, 1'b0, 64'd7,  64'd11, "R7");
        step(1'b1, 1'b0, 64'd1000, 64'd1000, "R2");

        // R4: hold with clear and operands wiggling
        step(1'b0, 1'b1, '1, '1, "R4");
        step(1'b0, 1'b0, 64'h1234, 64'h5678, "R4");

        // R5: clear drops the old sum
        step(1'b1, 1'b1, 64'd100, 64'd3, "R5");

        // R6: all-ones operands, full width product
        step(1'b1, 1'b1, '1, '1, "R6");
        step(1'b1, 1'b0, '1, '1, "R2");
        // R3: third maximal product carries out of the top bit
        step(1'b1, 1'b0, '1, '1, "R3");
        step(1'b0, 1'b0, '1, '1, "R3");
        step(1'b1, 1'b0, 64'd2, 64'd9, "R3");
        step(1'b0, 1'b1, '1, '1, "R4");
        // R5: clear also clears the flag
        step(1'b1, 1'b1, 64'd5, 64'd6, "R5");

        // R7: random mix of hold, load and accumulate on every cycle
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 2)       step(1'b0, 1'($urandom % 2), rand_op(), rand_op(), "R4");
            else if (r == 2) step(1'b1, 1'b1, rand_op(), rand_op(), "R5");
            else             step(1'b1, 1'b0, rand_op(), rand_op(), "R7");
        end

        // R1: asynchronous reset mid-run, seen before any clock edge
        step(1'b1, 1'b0, '1, 64'd77, "R2");
        #5;
        rst_n   = 1'b0;
        ref_sum = '0;
        ref_ovf = 1'b0;
        #1;
        check("R1");
        en = 1'b0;
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        step(1'b1, 1'b0, 64'd4, 64'd4, "R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule